// File: doc/BRIEF.md
# PCI Configuration Space Responder

This block answers configuration-space accesses for one emulated PCI function. A requester presents a byte offset, an access size, optional write data and a read and/or write strobe. Reads are answered one clock later on a registered data port with a valid flag. Writes take effect at the same clock edge.

The function reports fixed identity values: vendor, device, class, subclass and a header type of zero. It keeps a 16-bit command register and two live base address registers. BAR0 is a 1-byte I/O window and BAR1 is a 256-byte 32-bit memory window. The other four BAR slots are unimplemented. Writing all ones to a live BAR arms the usual sizing probe. A standard capability list and an extended capability list can be walked through their ID and next-pointer fields.

Top module: `pci_cfg_responder`

## Requirements
- R1: Offset 0x000 reads VENDOR_ID and offset 0x002 reads DEVICE_ID, each in bits 15:0. Offset 0x00B reads CLASS_CODE in bits 7:0. Offset 0x00E (header type) reads 0.
- R2: At offset 0x00A, a byte access (size code 0) returns SUBCLASS in bits 7:0. Any wider access (size code 1 = 16-bit, 2 = 32-bit) returns CLASS_CODE in bits 15:8 and SUBCLASS in bits 7:0.
- R3: The command register at offset 0x004 stores write data bits 15:0 verbatim and reads back zero-extended. It resets to 0.
- R4: BAR0 (offset 0x010) and BAR1 (offset 0x014) store all 32 written bits. The stored bit 0 is ORed with the BAR's space bit (1 for the I/O BAR0, 0 for BAR1), so the I/O indicator of BAR0 cannot be cleared. After reset BAR0 reads 0x00000001 and BAR1 reads 0.
- R5: A BAR holding 0xFFFFFFFF returns its sizing value instead of its contents. For BAR0 this is (~(size-1) & 0xFFFFFFFC) | 1, which is 0xFFFFFFFD for size 1. For BAR1 it is ~(size-1) & 0xFFFFFFF0, which is 0xFFFFFF00 for size 256.
- R6: The BAR slots at offsets 0x018, 0x01C, 0x020 and 0x024 always read 0, and writes to them have no effect.
- R7: The standard capability list is as follows.
  - Offset 0x034 reads 0x40.
  - 0x040 reads 0x5001: next 0x50 in bits 15:8, power-management ID 0x01.
  - 0x050 reads 0x7010: next 0x70, PCIe ID 0x10.
  - 0x070 reads 0x11 (MSI-X ID, next 0).
  - The next-pointer bytes 0x041, 0x051 and 0x071 read 0x50, 0x70 and 0 on their own.
- R8: The extended capability headers hold the next offset in bits 31:20, 0 in bits 19:16 and the ID in bits 15:0. Offset 0x100 reads 0x14000001 (error reporting, next 0x140). Offset 0x140 reads 0x18000002 (virtual channel, next 0x180). Offset 0x180 reads 0x00000003 (serial number, end of list).
- R9: Any offset not named in R1 to R8 reads 0, and writes to such offsets (including the read-only identity offsets) change no readable value.
- R10: A read strobe yields cfg_rvalid high with cfg_rdata valid in the following cycle only. A read and a write in the same cycle see the offset's value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_off | input | 12 | Configuration byte offset |
| cfg_size | input | 2 | Access size: 0 byte, 1 half-word, 2 word |
| cfg_wdata | input | 32 | Write data |
| cfg_we | input | 1 | Write strobe |
| cfg_re | input | 1 | Read strobe |
| cfg_rdata | output | 32 | Registered read data |
| cfg_rvalid | output | 1 | Read data valid, one cycle after cfg_re |

## Verification
A read and a write can land on the same offset in the same cycle. This matters most for the command register and the two live BARs, where the write can also arm or disarm the sizing probe. The bench raises both strobes together, both in directed cases (writing all ones to a BAR while reading it) and at random. It expects the read data to show the register as it stood before the write. A following read then shows the new value, or its sizing code.

// File: rtl/pci_cfg_responder.sv
module pci_cfg_responder #(
  parameter logic [15:0] VENDOR_ID  = 16'hC0DE,
  parameter logic [15:0] DEVICE_ID  = 16'h5CA5,
  parameter logic [7:0]  CLASS_CODE = 8'hFF,
  parameter logic [7:0]  SUBCLASS   = 8'h80,
  parameter int unsigned BAR0_SIZE  = 1,
  parameter int unsigned BAR1_SIZE  = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [11:0] cfg_off,
  input  logic [1:0]  cfg_size,
  input  logic [31:0] cfg_wdata,
  input  logic        cfg_we,
  input  logic        cfg_re,
  output logic [31:0] cfg_rdata,
  output logic        cfg_rvalid
);

  localparam logic [7:0]  CAP_PM   = 8'h40;
  localparam logic [7:0]  CAP_EXP  = 8'h50;
  localparam logic [7:0]  CAP_MSIX = 8'h70;
  localparam logic [11:0] EXT_ERR  = 12'h100;
  localparam logic [11:0] EXT_VC   = 12'h140;
  localparam logic [11:0] EXT_SN   = 12'h180;
  localparam logic [31:0] IO_MASK  = 32'hFFFF_FFFC;
  localparam logic [31:0] MEM_MASK = 32'hFFFF_FFF0;
  localparam logic [31:0] BAR0_PROBE = (~(32'(BAR0_SIZE) - 32'd1) & IO_MASK) | 32'd1;
  localparam logic [31:0] BAR1_PROBE = ~(32'(BAR1_SIZE) - 32'd1) & MEM_MASK;

  logic [15:0] cmd_q;
  logic [31:0] bar0_q, bar1_q;
  logic [31:0] rd_mux;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      bar0_q <= 32'd1;
      bar1_q <= '0;
    end else if (cfg_we) begin
      case (cfg_off)
        12'h004: cmd_q  <= cfg_wdata[15:0];
        12'h010: bar0_q <= cfg_wdata | 32'd1;
        12'h014: bar1_q <= cfg_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (cfg_off)
      12'h000: rd_mux = {16'h0, VENDOR_ID};
      12'h002: rd_mux = {16'h0, DEVICE_ID};
      12'h004: rd_mux = {16'h0, cmd_q};
      12'h00A: rd_mux = (cfg_size == 2'd0) ? {24'h0, SUBCLASS} : {16'h0, CLASS_CODE, SUBCLASS};
      12'h00B: rd_mux = {24'h0, CLASS_CODE};
      12'h00E: rd_mux = '0;
      12'h010: rd_mux = (&bar0_q) ? BAR0_PROBE : bar0_q;
      12'h014: rd_mux = (&bar1_q) ? BAR1_PROBE : bar1_q;
      12'h034: rd_mux = {24'h0, CAP_PM};
      12'h040: rd_mux = {16'h0, CAP_EXP, 8'h01};
      12'h041: rd_mux = {24'h0, CAP_EXP};
      12'h050: rd_mux = {16'h0, CAP_MSIX, 8'h10};
      12'h051: rd_mux = {24'h0, CAP_MSIX};
      12'h070: rd_mux = 32'h11;
      12'h071: rd_mux = '0;
      EXT_ERR: rd_mux = {EXT_VC, 20'h00001};
      EXT_VC:  rd_mux = {EXT_SN, 20'h00002};
      EXT_SN:  rd_mux = 32'h0000_0003;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_rdata  <= '0;
      cfg_rvalid <= 1'b0;
    end else begin
      cfg_rvalid <= cfg_re;
      if (cfg_re) cfg_rdata <= rd_mux;
    end
  end

  AST_RVALID_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_re |=> cfg_rvalid); // R10
  AST_RVALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_re |=> !cfg_rvalid); // R10
  AST_CMD_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_off == 12'h004) |=> cmd_q == $past(cfg_wdata[15:0])); // R3
  AST_IO_BIT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_off == 12'h010) |=> (bar0_q[0] && bar0_q[31:1] == $past(cfg_wdata[31:1]))); // R4
  AST_HDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_re && cfg_off == 12'h00E) |=> cfg_rdata == 32'h0); // R1
  AST_UNUSED_BAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_re && cfg_off >= 12'h018 && cfg_off <= 12'h024 && cfg_off[1:0] == 2'b00) |=> cfg_rdata == 32'h0); // R6
  AST_EXT_LIST_END: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_re && cfg_off == EXT_SN) |=> cfg_rdata[31:20] == 12'h0); // R8

endmodule

// File: tb/pci_cfg_responder_test.sv
module pci_cfg_responder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] cfg_off = '0;
  logic [1:0]  cfg_size = 2'd2;
  logic [31:0] cfg_wdata = '0;
  logic        cfg_we = 1'b0;
  logic        cfg_re = 1'b0;
  logic [31:0] cfg_rdata;
  logic        cfg_rvalid;

  int checks = 0;
  int failures = 0;
  logic [15:0] m_cmd;
  logic [31:0] m_bar0, m_bar1;

  always #5 clk = ~clk;

  pci_cfg_responder uut (
    .clk(clk), .rst_n(rst_n), .cfg_off(cfg_off), .cfg_size(cfg_size),
    .cfg_wdata(cfg_wdata), .cfg_we(cfg_we), .cfg_re(cfg_re),
    .cfg_rdata(cfg_rdata), .cfg_rvalid(cfg_rvalid)
  );

  function automatic logic [31:0] expect_rd(input logic [11:0] off, input logic [1:0] sz);
    case (off)
      12'h000: return 32'h0000C0DE;
      12'h002: return 32'h00005CA5;
      12'h004: return {16'h0, m_cmd};
      12'h00A: return (sz == 2'd0) ? 32'h80 : 32'hFF80;
      12'h00B: return 32'hFF;
      12'h010: return (m_bar0 == 32'hFFFFFFFF) ? 32'hFFFFFFFD : m_bar0;
      12'h014: return (m_bar1 == 32'hFFFFFFFF) ? 32'hFFFFFF00 : m_bar1;
      12'h034: return 32'h40;
      12'h040: return 32'h5001;
      12'h041: return 32'h50;
      12'h050: return 32'h7010;
      12'h051: return 32'h70;
      12'h070: return 32'h11;
      12'h100: return 32'h14000001;
      12'h140: return 32'h18000002;
      12'h180: return 32'h00000003;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [11:0] off);
    case (off)
      12'h000, 12'h002, 12'h00B, 12'h00E: return "R1";
      12'h00A: return "R2";
      12'h004: return "R3";
      12'h010, 12'h014: return "R5";
      12'h018, 12'h01C, 12'h020, 12'h024: return "R6";
      12'h034, 12'h040, 12'h041, 12'h050, 12'h051, 12'h070, 12'h071: return "R7";
      12'h100, 12'h140, 12'h180: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_write(input logic [11:0] off, input logic [31:0] d);
    case (off)
      12'h004: m_cmd = d[15:0];
      12'h010: m_bar0 = d | 32'd1;
      12'h014: m_bar1 = d;
      default: ;
    endcase
  endtask

  task automatic access(input bit we, input bit re, input logic [11:0] off,
                        input logic [1:0] sz, input logic [31:0] d, input string tag);
    logic [31:0] exp;
    exp = expect_rd(off, sz);
    @(negedge clk);
    cfg_we = we; cfg_re = re; cfg_off = off; cfg_size = sz; cfg_wdata = d;
    @(posedge clk);
    #1;
    if (re) begin
      check({tag, " rvalid"}, {31'h0, cfg_rvalid}, 32'd1);
      check(tag, cfg_rdata, exp);
    end
    if (we) model_write(off, d);
    @(negedge clk);
    cfg_we = 1'b0; cfg_re = 1'b0;
  endtask

  localparam int NOFF = 24;
  logic [11:0] offs [NOFF] = '{12'h000, 12'h002, 12'h004, 12'h00A, 12'h00B, 12'h00E,
    12'h010, 12'h014, 12'h018, 12'h01C, 12'h020, 12'h024, 12'h034, 12'h040, 12'h041,
    12'h050, 12'h051, 12'h070, 12'h071, 12'h100, 12'h140, 12'h180, 12'h0FC, 12'h3FC};

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    m_cmd = '0; m_bar0 = 32'd1; m_bar1 = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    check("R10 idle rvalid", {31'h0, cfg_rvalid}, 32'd0);
    // reset state
    access(0, 1, 12'h004, 2'd2, 0, "R3 reset");
    access(0, 1, 12'h010, 2'd2, 0, "R4 reset");
    access(0, 1, 12'h014, 2'd2, 0, "R4 reset");
    access(0, 1, 12'h000, 2'd1, 0, "R1");
    access(0, 1, 12'h002, 2'd1, 0, "R1");
    access(0, 1, 12'h00E, 2'd0, 0, "R1");
    access(0, 1, 12'h00A, 2'd0, 0, "R2 byte");
    access(0, 1, 12'h00A, 2'd1, 0, "R2 half");
    access(0, 1, 12'h00A, 2'd2, 0, "R2 word");
    // BAR writes and sizing
    access(1, 0, 12'h010, 2'd2, 32'h0, "R4");
    access(0, 1, 12'h010, 2'd2, 0, "R4 io bit kept");
    access(1, 0, 12'h014, 2'd2, 32'hFFFFFFFF, "R5");
    access(0, 1, 12'h014, 2'd2, 0, "R5 mem probe");
    access(1, 0, 12'h010, 2'd2, 32'hFFFFFFFE, "R5");
    access(0, 1, 12'h010, 2'd2, 0, "R5 io probe");
    access(1, 0, 12'h014, 2'd2, 32'hE000_0000, "R4");
    access(0, 1, 12'h014, 2'd2, 0, "R4 mem base");
    // unused BAR and read-only offsets
    access(1, 0, 12'h018, 2'd2, 32'hFFFFFFFF, "R6");
    access(0, 1, 12'h018, 2'd2, 0, "R6");
    access(1, 0, 12'h000, 2'd2, 32'h12345678, "R9");
    access(0, 1, 12'h000, 2'd2, 0, "R9 vendor unchanged");
    access(1, 0, 12'h040, 2'd2, 32'h0, "R9");
    access(0, 1, 12'h040, 2'd2, 0, "R9 cap unchanged");
    access(0, 1, 12'h200, 2'd2, 0, "R9 unlisted");
    // capability walks
    for (int i = 12; i < 22; i++) access(0, 1, offs[i], 2'd2, 0, tag_of(offs[i]));
    // same-cycle read and write
    access(1, 1, 12'h004, 2'd1, 32'h0000BEEF, "R10 rw cmd old");
    access(0, 1, 12'h004, 2'd1, 0, "R10 rw cmd new");
    access(1, 1, 12'h014, 2'd2, 32'hFFFFFFFF, "R10 rw bar old");
    access(0, 1, 12'h014, 2'd2, 0, "R10 rw bar probe");
    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [11:0] o;
      logic [31:0] d;
      bit w, r;
      o = ($urandom % 5 == 0) ? 12'($urandom) : offs[$urandom % NOFF];
      if ($urandom % 3 == 0) o = ($urandom % 2) ? 12'h010 : 12'h014;
      d = ($urandom % 4 == 0) ? 32'hFFFFFFFF : $urandom;
      w = ($urandom % 3 == 0);
      r = !w || ($urandom % 2 == 0);
      access(w, r, o, 2'($urandom % 3), d, tag_of(o));
    end
    @(negedge clk);
    check("R10 idle rvalid", {31'h0, cfg_rvalid}, 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule